// File: doc/BRIEF.md
# Programmable IDE Strobe Timing Generator

This block times one access to an IDE port, counted in bus-clock cycles. A host request starts the access. The generator then drives a select signal for a programmed number of cycles. After a programmed delay inside that window, it raises the read strobe or the write strobe. Both signals drop together on the last cycle of the window. A one-cycle completion pulse follows.

The timing pair is picked from an eight-entry table by a three-bit code held in a byte-wide speed register, which the host can write and read. When the request carries address bit A6 set, the register is bypassed and a slow timing is used. This timing is safe for byte-wide command accesses. Address bits A4..A2 of the request pick the IDE register. They are passed through and held for the whole access.

Top module: `ide_strobe_timer`

## Requirements
- R1: The speed register reads back as its three-bit timing code in bits 7..5, with bits 4..0 always 1. After reset it reads 8'h1F, which is code 0. A write loads bits 7..5 of the write data.
- R2: The code selects (select cycles, strobe delay) as follows: 0→(7,2), 1→(9,3), 2→(11,4), 3→(5,1), 4→(5,2), 5→(5,3), 6→(15,4), 7→(5,1).
- R3: A request with A6 = 1 uses 11 select cycles and a strobe delay of 4, whatever the speed code.
- R4: A request sampled at a clock edge while select is low raises select from that edge. Select stays high for exactly the select-cycle count. The strobe rises after the delay count of select cycles and falls on the same edge as select.
- R5: A read (write flag 0) pulses only the read strobe, and a write (write flag 1) pulses only the write strobe. The two strobes are never high together, and never high without select.
- R6: The IDE register address output carries the request's A4..A2 bits and stays stable while select is high.
- R7: A request presented while select is high is ignored. It neither lengthens the current access nor starts a new one.
- R8: The done output is high for exactly one cycle, starting one clock after select falls.
- R9: The timing is captured when an access starts. A speed-register write during an access affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| req_a6 | input | 1 | Address bit A6; 1 forces the slow command timing |
| req_reg | input | 3 | Address bits A4..A2 (IDE register index) |
| spd_we | input | 1 | Speed register write enable |
| spd_wdata | input | 8 | Speed register write data |
| spd_rdata | output | 8 | Speed register read data |
| ide_sel | output | 1 | IDE select |
| ide_ior | output | 1 | Read strobe, active high |
| ide_iow | output | 1 | Write strobe, active high |
| ide_addr | output | 3 | IDE register address |
| done | output | 1 | One-cycle completion pulse |

## Verification
Select is due in the first sample after the edge that takes the request. The strobe is due a delay count of samples later. Select and the strobe must be low again exactly one select-cycle count after select rose, and done must appear in the following sample only. The bench drives inputs on falling edges and samples on falling edges, one sample per cycle, numbered from the edge that accepts the request. It checks those sample indices against a timing table of its own for every code and for the A6 override. Speed readback is checked one cycle after each write.

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_wr,
  input  logic       req_a6,
  input  logic [2:0] req_reg,
  input  logic       spd_we,
  input  logic [7:0] spd_wdata,
  output logic [7:0] spd_rdata,
  output logic       ide_sel,
  output logic       ide_ior,
  output logic       ide_iow,
  output logic [2:0] ide_addr,
  output logic       done
);

  logic [2:0]       spd_q;
  logic [CNT_W-1:0] cnt, len_q, dly_q, len_d, dly_d;
  logic             wr_q, last_q, strobe;

  always_comb begin
    unique case (spd_q)
      3'd0:    begin len_d = CNT_W'(7);  dly_d = CNT_W'(2); end
      3'd1:    begin len_d = CNT_W'(9);  dly_d = CNT_W'(3); end
      3'd2:    begin len_d = CNT_W'(11); dly_d = CNT_W'(4); end
      3'd4:    begin len_d = CNT_W'(5);  dly_d = CNT_W'(2); end
      3'd5:    begin len_d = CNT_W'(5);  dly_d = CNT_W'(3); end
      3'd6:    begin len_d = CNT_W'(15); dly_d = CNT_W'(4); end
      default: begin len_d = CNT_W'(5);  dly_d = CNT_W'(1); end
    endcase
    if (req_a6) begin
      len_d = CNT_W'(11);
      dly_d = CNT_W'(4);
    end
  end

  assign spd_rdata = {spd_q, 5'b11111};
  assign strobe    = ide_sel && (cnt >= dly_q);
  assign ide_ior   = strobe && !wr_q;
  assign ide_iow   = strobe && wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spd_q    <= '0;
      ide_sel  <= 1'b0;
      cnt      <= '0;
      len_q    <= '0;
      dly_q    <= '0;
      wr_q     <= 1'b0;
      ide_addr <= '0;
      last_q   <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (spd_we) spd_q <= spd_wdata[7:5];
      last_q <= ide_sel && (cnt == len_q - 1'b1);
      done   <= last_q;
      if (!ide_sel) begin
        if (req) begin
          ide_sel  <= 1'b1;
          cnt      <= '0;
          len_q    <= len_d;
          dly_q    <= dly_d;
          wr_q     <= req_wr;
          ide_addr <= req_reg;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == len_q - 1'b1) ide_sel <= 1'b0;
      end
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_ior && ide_iow)); // R5
  AST_STB_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_ior || ide_iow) |-> ide_sel); // R5
  AST_STB_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_sel) |-> $past(ide_ior || ide_iow)); // R4
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(ide_sel) && $past(ide_sel, 2)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_sel && $past(ide_sel)) |-> $stable(ide_addr)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_ior && $past(ide_sel)) |-> !$past(ide_iow)); // R5

endmodule

// File: tb/ide_strobe_timer_test.sv
module ide_strobe_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, req_wr = 1'b0, req_a6 = 1'b0;
  logic [2:0] req_reg = '0;
  logic       spd_we = 1'b0;
  logic [7:0] spd_wdata = '0;
  logic [7:0] spd_rdata;
  logic       ide_sel, ide_ior, ide_iow, done;
  logic [2:0] ide_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ide_strobe_timer uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_a6(req_a6),
    .req_reg(req_reg), .spd_we(spd_we), .spd_wdata(spd_wdata),
    .spd_rdata(spd_rdata), .ide_sel(ide_sel), .ide_ior(ide_ior),
    .ide_iow(ide_iow), .ide_addr(ide_addr), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int tbl_len(input int code);
    int l [8] = '{7, 9, 11, 5, 5, 5, 15, 5};
    return l[code];
  endfunction

  function automatic int tbl_dly(input int code);
    int d [8] = '{2, 3, 4, 1, 2, 3, 4, 1};
    return d[code];
  endfunction

  task automatic write_speed(input int code);
    @(negedge clk);
    spd_we = 1'b1; spd_wdata = 8'(code << 5);
    @(negedge clk);
    spd_we = 1'b0;
    chk("R1 readback", spd_rdata, (code << 5) | 'h1f);
  endtask

  // mode 0 plain, 1 extra request mid-access (R7), 2 speed write mid-access (R9)
  task automatic run_access(input string tag, input bit wr, input bit a6,
                            input int regi, input int exp_len, input int exp_dly,
                            input int mode);
    int sel_n = 0, first_stb = -1, stb_n = 0, done_at = -1, done_n = 0;
    int rises = 0, bad_dir = 0, bad_addr = 0, both = 0;
    bit prev_sel = 0;
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_a6 = a6; req_reg = 3'(regi);
    @(negedge clk);
    req = 1'b0; req_a6 = 1'b0; req_reg = 3'(~regi);
    for (int i = 0; i < 24; i++) begin
      if (ide_sel && !prev_sel) rises++;
      prev_sel = ide_sel;
      if (ide_sel) begin
        sel_n++;
        if (ide_addr != 3'(regi)) bad_addr++;
      end
      if (ide_ior || ide_iow) begin
        stb_n++;
        if (first_stb < 0) first_stb = i;
        if (wr ? ide_ior : ide_iow) bad_dir++;
      end
      if (ide_ior && ide_iow) both++;
      if (done) begin
        done_n++;
        if (done_at < 0) done_at = i;
      end
      if (mode == 1 && i == 2) begin req = 1'b1; req_wr = ~wr; end
      if (mode == 1 && i == 4) req = 1'b0;
      if (mode == 2 && i == 1) begin spd_we = 1'b1; spd_wdata = 8'hC0; end
      if (mode == 2 && i == 2) spd_we = 1'b0;
      @(negedge clk);
    end
    chk({tag, " R4 select cycles"}, sel_n, exp_len);
    chk({tag, " R4 strobe start"}, first_stb, exp_dly);
    chk({tag, " R4 strobe ends with select"}, stb_n, exp_len - exp_dly);
    chk({tag, " R5 strobe direction"}, bad_dir + both, 0);
    chk({tag, " R6 address"}, bad_addr, 0);
    chk({tag, " R8 done position"}, done_at, exp_len + 1);
    chk({tag, " R8 done width"}, done_n, 1);
    chk({tag, " R7 single access"}, rises, 1);
  endtask

  task automatic test_reset;
    chk("R1 reset readback", spd_rdata, 'h1f);
    chk("R4 reset select", ide_sel, 0);
    chk("R5 reset strobes", ide_ior | ide_iow, 0);
    chk("R8 reset done", done, 0);
  endtask

  task automatic test_table;
    for (int c = 0; c < 8; c++) begin
      write_speed(c);
      run_access($sformatf("R2 code %0d read", c), 0, 0, c, tbl_len(c), tbl_dly(c), 0);
      run_access($sformatf("R2 code %0d write", c), 1, 0, 7 - c, tbl_len(c), tbl_dly(c), 0);
    end
  endtask

  task automatic test_a6;
    write_speed(6);
    run_access("R3 over code 6", 0, 1, 5, 11, 4, 0);
    write_speed(3);
    run_access("R3 over code 3", 1, 1, 2, 11, 4, 0);
    run_access("R3 next without A6", 1, 0, 2, 5, 1, 0);
  endtask

  task automatic test_ignore;
    write_speed(0);
    run_access("R7 request while busy", 0, 0, 4, 7, 2, 1);
  endtask

  task automatic test_latch;
    write_speed(1);
    run_access("R9 write during access", 1, 0, 1, 9, 3, 2);
    chk("R9 new code readback", spd_rdata, 'hDF);
    run_access("R9 following access", 0, 0, 6, 15, 4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_table();
    test_a6();
    test_ignore();
    test_latch();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule